// File: doc/BRIEF.md
# Optical Module Sideband Status Tracker

This block watches three slow sideband lines from a pluggable optical module: receive loss of signal, transmit fault and module absent. Each line is asynchronous to the system clock, so each passes through its own multi-flop synchroniser. The block reports the synchronised level of every line. Next to each level it keeps a sticky change flag, which records that the line has moved since software last read the status word.

The status word sits behind a single readback register on a simple peripheral bus. A one-cycle read strobe returns the word as it stands in that cycle. The same strobe clears all change flags from the next cycle on. A transition detected in the read cycle itself is not lost: its flag stays set after the read, so software sees it on the following read. After reset, the first valid synchronised sample of each line primes that line's change detector. A line held high through reset therefore shows its level without a false change flag.

Top module: `sfp_sideband_status`

## Requirements
- R1: Bit 0 of `rd_data` is the receive-loss level, bit 1 is the transmit-fault level and bit 2 is the module-absent level (1 = no module, 0 = module present). A level bit follows its input within 3 clock cycles of a change that then holds steady.
- R2: Bits 3, 4 and 5 are the change flags for receive loss, transmit fault and module absent, in that order. A flag is set within 4 clock cycles of a change on its input.
- R3: A set change flag stays set, across further changes of its input and any number of idle cycles, until a read strobe.
- R4: In the cycle where `rd_stb` is high, `rd_data` shows the flags as they stood before the read. From the next cycle on, every flag without a new change is 0.
- R5: If a change on an input is detected in the same cycle as a read strobe, that input's flag is 1 after the read. Other flags are still cleared.
- R6: Bits 6 and above of `rd_data` always read as 0.
- R7: While reset is asserted, `rd_data` is all zeros. After reset, no change flag is set by the first synchronised samples, even when an input is held high through reset.
- R8: A change on one input sets only that input's flag.
- R9: A healthy, present module (all three inputs low) reads with the three level bits at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_los_in | input | 1 | Receive loss-of-signal line, asynchronous |
| tx_fault_in | input | 1 | Transmit fault line, asynchronous |
| mod_absent_in | input | 1 | Module-absent line, asynchronous, high when no module is present |
| rd_stb | input | 1 | One-cycle read strobe of the status register; clears change flags |
| rd_data | output | DATA_W | Status word: levels in bits 2:0, change flags in bits 5:3, zeros above |

## Verification
The two functions that can fall in the same cycle are clearing the change flags on a read and setting a flag on a newly detected edge. The bench provokes this case by timing an input change so that the synchroniser's output moves exactly in the cycle where the read strobe is high. It starts from a state where another flag is already set. It judges the outcome from the status word in two places. The word returned during the read must still show only the old flag. The word after the read must show the old flag cleared and the colliding flag set.

// File: rtl/sfp_stat_pkg.sv
package sfp_stat_pkg;
    localparam int NUM_SIG = 3;

    typedef struct packed {
        logic prev;
        logic primed;
        logic flag;
    } trk_state_t;
endpackage

// File: rtl/sfp_sync_bit.sv
module sfp_sync_bit #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_o,
    output logic valid_o
);
    typedef struct packed {
        logic [STAGES-1:0] pipe;
        logic [STAGES-1:0] vld;
    } sync_state_t;

    sync_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.pipe = {st_q.pipe[STAGES-2:0], async_in};
        st_d.vld  = {st_q.vld[STAGES-2:0], 1'b1};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sync_o  = st_q.pipe[STAGES-1];
    assign valid_o = st_q.vld[STAGES-1];

    // R7: once the pipeline is filled it stays valid until reset
    a_r7_valid_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> valid_o);
endmodule

// File: rtl/sfp_change_track.sv
module sfp_change_track
    import sfp_stat_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic level_i,
    input  logic valid_i,
    input  logic clr_i,
    output logic flag_o
);
    trk_state_t st_d, st_q;
    logic       edge_det;

    always_comb begin
        st_d     = st_q;
        edge_det = st_q.primed && valid_i && (level_i != st_q.prev);
        if (valid_i) begin
            st_d.prev   = level_i;
            st_d.primed = 1'b1;
        end
        st_d.flag = (st_q.flag && !clr_i) || edge_det;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flag_o = st_q.flag;

    // R2: a detected change shows as a set flag on the next cycle
    a_r2_edge_sets: assert property (@(posedge clk) disable iff (!rst_n)
        edge_det |=> flag_o);
    // R3: without a read the flag holds
    a_r3_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_o && !clr_i) |=> flag_o);
    // R4: a read with no new change leaves the flag clear
    a_r4_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !edge_det) |=> !flag_o);
    // R5: a change in the read cycle survives the read
    a_r5_collision_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && edge_det) |=> flag_o);
    // R7: before priming no flag can appear
    a_r7_no_false_flag: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.primed |=> !flag_o);
endmodule

// File: rtl/sfp_sideband_status.sv
module sfp_sideband_status
    import sfp_stat_pkg::*;
#(
    parameter int DATA_W      = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_los_in,
    input  logic              tx_fault_in,
    input  logic              mod_absent_in,
    input  logic              rd_stb,
    output logic [DATA_W-1:0] rd_data
);
    localparam int PAD_W = DATA_W - 2 * NUM_SIG;

    logic [NUM_SIG-1:0] raw_in;
    logic [NUM_SIG-1:0] level_s;
    logic [NUM_SIG-1:0] valid_s;
    logic [NUM_SIG-1:0] flag_s;

    // bit order of raw_in fixes the status word layout (R1, R2)
    assign raw_in = {mod_absent_in, tx_fault_in, rx_los_in};

    for (genvar g = 0; g < NUM_SIG; g++) begin : g_line
        sfp_sync_bit #(.STAGES(SYNC_STAGES)) u_sync (
            .clk     (clk),
            .rst_n   (rst_n),
            .async_in(raw_in[g]),
            .sync_o  (level_s[g]),
            .valid_o (valid_s[g])
        );

        sfp_change_track u_trk (
            .clk    (clk),
            .rst_n  (rst_n),
            .level_i(level_s[g]),
            .valid_i(valid_s[g]),
            .clr_i  (rd_stb),
            .flag_o (flag_s[g])
        );
    end

    assign rd_data = {{PAD_W{1'b0}}, flag_s, level_s};
endmodule

// File: tb/sfp_sideband_status_bench.sv
module sfp_sideband_status_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  sig = 3'b000;
    logic        rd_stb = 1'b0;
    logic [31:0] rd_data;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    sfp_sideband_status u_sfp_sideband_status (
        .clk          (clk),
        .rst_n        (rst_n),
        .rx_los_in    (sig[0]),
        .tx_fault_in  (sig[1]),
        .mod_absent_in(sig[2]),
        .rd_stb       (rd_stb),
        .rd_data      (rd_data)
    );

    // fields: input levels[9:7], read after check[6], expected rd_data[5:0]
    localparam logic [9:0] VEC [13] = '{
        {3'b000, 1'b1, 6'b000_000},   // healthy module (R9)
        {3'b001, 1'b1, 6'b001_001},   // loss of signal appears
        {3'b001, 1'b1, 6'b000_001},   // read cleared it
        {3'b011, 1'b0, 6'b010_011},   // fault only (R8)
        {3'b111, 1'b1, 6'b110_111},   // absent added, fault flag kept (R3)
        {3'b111, 1'b1, 6'b000_111},
        {3'b110, 1'b0, 6'b001_110},
        {3'b100, 1'b0, 6'b011_100},
        {3'b000, 1'b1, 6'b111_000},
        {3'b000, 1'b1, 6'b000_000},
        {3'b100, 1'b1, 6'b100_100},   // module removed
        {3'b000, 1'b0, 6'b100_000},   // module inserted
        {3'b000, 1'b1, 6'b100_000}    // still held without a read (R3)
    };

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: rd_data=%h expected %h", req, got, exp);
        end
    endtask

    task automatic read_pulse();
        rd_stb = 1'b1;
        @(negedge clk);
        rd_stb = 1'b0;
    endtask

    initial begin
        // R7: zeros during reset
        repeat (3) @(negedge clk);
        check("R7 reset", rd_data, 32'h0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check("R9 R1 idle after reset", rd_data, 32'h0);

        for (int i = 0; i < 13; i++) begin
            logic [2:0] vin;
            logic       vrd;
            logic [5:0] vexp;
            {vin, vrd, vexp} = VEC[i];
            sig = vin;
            repeat (4) @(negedge clk);
            check("R1 R2 R3 R4 R6 R8 vector", rd_data, {26'd0, vexp});
            if (vrd) read_pulse();
        end

        // state: sig=000, flags clear
        // R5: flag on transmit fault, then a receive-loss edge lands in the read cycle
        sig = 3'b010;
        repeat (4) @(negedge clk);
        check("R2 fault flag before collision", rd_data, {26'd0, 6'b010_010});
        sig = 3'b011;
        @(negedge clk);              // first stage captured
        @(negedge clk);              // second stage captured, edge pending
        rd_stb = 1'b1;
        check("R4 value returned in read cycle", rd_data, {26'd0, 6'b010_011});
        @(negedge clk);
        rd_stb = 1'b0;
        check("R5 collision edge kept, other flag cleared", rd_data, {26'd0, 6'b001_011});
        read_pulse();
        check("R4 next read clears", rd_data, {26'd0, 6'b000_011});

        // R3: sticky over many idle cycles
        sig = 3'b111;
        repeat (30) @(negedge clk);
        check("R3 sticky after idle", rd_data, {26'd0, 6'b100_111});

        // R7: inputs held high through reset give no false flag
        rst_n = 1'b0;
        sig   = 3'b101;
        repeat (2) @(negedge clk);
        check("R7 zeros in reset", rd_data, 32'h0);
        rst_n = 1'b1;
        repeat (6) @(negedge clk);
        check("R7 no false flag after reset", rd_data, {26'd0, 6'b000_101});
        check("R6 upper bits zero", {6'd0, rd_data[31:6]}, 32'h0);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule